// File: doc/BRIEF.md
# CAN Standard Frame Receiver

This block is the receive side of a CAN controller for standard (11-bit identifier) frames. A bit-timing unit upstream provides a one-clock strobe at the sample point of every bit, and the bit stream reaching the block is already destuffed. The block needs a run of recessive bits before it treats the bus as idle. On an idle bus it takes a dominant bit as start-of-frame. It then walks through the arbitration, control, data, checksum, delimiter and end-of-frame fields one bit per strobe.

Each received bit goes to a serial CRC divider. A frame is accepted only when the division over the whole frame, the 15 checksum bits included, leaves a zero remainder. In that case the block pulls its transmit line dominant for the acknowledge slot. After the last end-of-frame bit it presents the identifier, remote-request flag, length code and data bytes together with a one-clock valid pulse. An extended-format frame, a checksum mismatch or a dominant bit where the format requires a recessive one ends the frame early. The block then raises a one-clock error pulse with a cause code and waits for the bus to go idle again.

Top module: `can_std_rx`

## Requirements
- R1: After reset or after any frame ends, a dominant bit is taken as start-of-frame only once IDLE_BITS (default 11) consecutive recessive bits have been sampled. A dominant bit inside that run restarts the count.
- R2: The identifier is received most significant bit first and shows on `frm_id`. The next bit shows on `frm_rtr`, and the 4-bit length code (MSB first) shows on `frm_dlc`. `frm_valid` is high for exactly one clock, in the cycle after the strobe that samples the seventh recessive end-of-frame bit.
- R3: A recessive bit in the format-select position after the remote-request bit ends the frame with `err_valid` and `err_code` = 2 (extended format unsupported). There is then no acknowledge and no `frm_valid`.
- R4: The reserved bit after the format-select bit may be either value and has no effect on the received frame.
- R5: The number of data bytes is the length code, with codes above 8 clamped to 8. `frm_dlc` still reports the raw code. Byte k occupies `frm_data[8k+7:8k]`, its first received bit in bit 8k+7. Bytes not received read zero.
- R6: The checksum uses the generator x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 (taps 0x4599) with a zero start value, over start-of-frame through the 15 checksum bits. A nonzero remainder raises `err_valid` with `err_code` = 3 in the cycle after the checksum-delimiter strobe. There is then no acknowledge and no `frm_valid`.
- R7: `tx_bit` is 1 (recessive) out of reset and at all times except one window: it is 0 from the cycle after a recessive checksum-delimiter strobe of a frame with a zero remainder until the cycle after the next (acknowledge-slot) strobe.
- R8: A dominant bit at the checksum delimiter, the acknowledge delimiter or any of the 7 end-of-frame bits raises `err_valid` with `err_code` = 1 (form error) in the next cycle, and no `frm_valid` follows.
- R9: `frm_valid` and `err_valid` are never high together. Each is a single-cycle pulse. `frm_id`, `frm_dlc` and `frm_data` change only in a cycle where `frm_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-clock pulse at each bit sample point |
| rx_bit | input | 1 | Destuffed receive line, 0 = dominant |
| tx_bit | output | 1 | Transmit line, 0 only during the acknowledge slot |
| frm_valid | output | 1 | One-clock pulse: a good frame was received |
| frm_id | output | ID_W | Received identifier |
| frm_rtr | output | 1 | Received remote-request bit |
| frm_dlc | output | DLC_W | Received length code, unclamped |
| frm_data | output | 8*MAX_BYTES | Received data bytes, byte 0 in the low bits |
| err_valid | output | 1 | One-clock pulse: frame aborted |
| err_code | output | 2 | Abort cause: 1 form, 2 extended, 3 checksum |

## Verification
The checker assumes `bit_stb` is a single-clock pulse with at least one idle clock between strobes. It also assumes `rx_bit` behaves as a wired-AND bus, so a dominant acknowledge driven by the block is seen back on the receive line. The bench drives one strobe every four clocks and forms each received bit as the AND of its own bit and `tx_bit`. It always sends exactly IDLE_BITS recessive bits between frames, and it stops a frame right after the bit that is expected to abort it, so that leftover bits never form a false start-of-frame. Random corruption is kept to the data and checksum fields, which leaves the frame length unchanged and makes a checksum mismatch the only possible outcome.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

   typedef enum logic [3:0] {
      ST_WAIT, ST_IDLE, ST_ID,  ST_RTR,  ST_IDE, ST_RSV, ST_DLC,
      ST_DATA, ST_CRC,  ST_CDEL, ST_ACK, ST_ADEL, ST_EOF
   } rx_state_e;

   typedef enum logic [1:0] {
      ERR_NONE = 2'd0,
      ERR_FORM = 2'd1,
      ERR_EXT  = 2'd2,
      ERR_CRC  = 2'd3
   } rx_err_e;

   typedef enum logic [2:0] {
      CAP_NONE, CAP_ID, CAP_RTR, CAP_DLC, CAP_DATA
   } cap_sel_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/can_rx_crc.sv
module can_rx_crc #(
   parameter int           W    = 15,
   parameter logic [W-1:0] POLY = 15'h4599
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic din,
   output logic zero
);

   logic [W-1:0] rem_q;
   logic [W-1:0] rem_nxt;
   logic         fb;

   assign fb = din ^ rem_q[W-1];

   // one XOR stage per register bit, tapped where the generator has a one
   for (genvar i = 0; i < W; i++) begin : g_stage
      if (i == 0) begin : g_lsb
         assign rem_nxt[i] = fb & POLY[i];
      end else begin : g_mid
         assign rem_nxt[i] = rem_q[i-1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rem_q <= '0;
      else if (clr) rem_q <= '0;
      else if (en)  rem_q <= rem_nxt;
   end

   assign zero = (rem_q == '0);

endmodule

// File: rtl/can_rx_fields.sv
module can_rx_fields
   import can_rx_pkg::*;
#(
   parameter int ID_W      = 11,
   parameter int DLC_W     = 4,
   parameter int MAX_BYTES = 8,
   parameter int CNT_W     = 7,
   localparam int DATA_W   = MAX_BYTES * 8,
   localparam int DI_W     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              din,
   input  logic              clr,
   input  cap_sel_e          sel,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              load,
   output logic [DLC_W-1:0]  dlc_live,
   output logic [ID_W-1:0]   id_o,
   output logic              rtr_o,
   output logic [DLC_W-1:0]  dlc_o,
   output logic [DATA_W-1:0] data_o
);

   logic [ID_W-1:0]   id_q;
   logic              rtr_q;
   logic [DLC_W-1:0]  dlc_q;
   logic [DATA_W-1:0] data_q;
   logic [DI_W-1:0]   didx;

   // byte number from the upper count bits, bit order reversed inside a byte
   assign didx = DI_W'({cnt[CNT_W-1:3], ~cnt[2:0]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q   <= '0;
         rtr_q  <= 1'b0;
         dlc_q  <= '0;
         data_q <= '0;
      end else if (clr) begin
         id_q   <= '0;
         rtr_q  <= 1'b0;
         dlc_q  <= '0;
         data_q <= '0;
      end else if (stb) begin
         unique case (sel)
            CAP_ID:   id_q       <= {id_q[ID_W-2:0], din};
            CAP_RTR:  rtr_q      <= din;
            CAP_DLC:  dlc_q      <= {dlc_q[DLC_W-2:0], din};
            CAP_DATA: data_q[didx] <= din;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_o   <= '0;
         rtr_o  <= 1'b0;
         dlc_o  <= '0;
         data_o <= '0;
      end else if (load) begin
         id_o   <= id_q;
         rtr_o  <= rtr_q;
         dlc_o  <= dlc_q;
         data_o <= data_q;
      end
   end

   assign dlc_live = dlc_q;

endmodule

// File: rtl/can_rx_ctrl.sv
module can_rx_ctrl
   import can_rx_pkg::*;
#(
   parameter int ID_W      = 11,
   parameter int DLC_W     = 4,
   parameter int MAX_BYTES = 8,
   parameter int CRC_W     = 15,
   parameter int EOF_BITS  = 7,
   parameter int IDLE_BITS = 11,
   parameter int CNT_W     = 7,
   localparam int NB_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic             din,
   input  logic             crc_zero,
   input  logic [DLC_W-1:0] dlc_live,
   output logic             crc_clr,
   output logic             crc_en,
   output logic             cap_clr,
   output cap_sel_e         cap_sel,
   output logic [CNT_W-1:0] cnt,
   output logic             load,
   output logic             valid,
   output logic             err_valid,
   output logic [1:0]       err_code,
   output logic             tx_bit
);

   localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_BITS - 1);
   localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_W - 1);
   localparam logic [CNT_W-1:0] DLC_LAST  = CNT_W'(DLC_W - 1);
   localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_W - 1);
   localparam logic [CNT_W-1:0] EOF_LAST  = CNT_W'(EOF_BITS - 1);

   rx_state_e        state;
   logic [CNT_W-1:0] cnt_q;
   logic [NB_W-1:0]  nbytes_q;
   logic [NB_W-1:0]  nb_next;
   logic [DLC_W-1:0] dlc_full;
   logic [CNT_W-1:0] data_last;
   logic             tx_q, valid_q, err_q;
   rx_err_e          code_q;

   assign dlc_full  = {dlc_live[DLC_W-2:0], din};
   assign nb_next   = (dlc_full > DLC_W'(MAX_BYTES)) ? NB_W'(MAX_BYTES) : NB_W'(dlc_full);
   assign data_last = (CNT_W'(nbytes_q) << 3) - CNT_W'(1);

   always_comb begin
      unique case (state)
         ST_ID:   cap_sel = CAP_ID;
         ST_RTR:  cap_sel = CAP_RTR;
         ST_DLC:  cap_sel = CAP_DLC;
         ST_DATA: cap_sel = CAP_DATA;
         default: cap_sel = CAP_NONE;
      endcase
   end

   assign crc_clr = (state == ST_WAIT) || (state == ST_IDLE);
   assign crc_en  = stb && (state inside {ST_ID, ST_RTR, ST_IDE, ST_RSV,
                                          ST_DLC, ST_DATA, ST_CRC});
   assign cap_clr = stb && (state == ST_IDLE) && !din;
   assign load    = stb && (state == ST_EOF) && din && (cnt_q == EOF_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_WAIT;
         cnt_q    <= '0;
         nbytes_q <= '0;
         tx_q     <= 1'b1;
         valid_q  <= 1'b0;
         err_q    <= 1'b0;
         code_q   <= ERR_NONE;
      end else begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         if (stb) begin
            unique case (state)
               ST_WAIT: begin
                  if (!din)                   cnt_q <= '0;
                  else if (cnt_q == IDLE_LAST) begin state <= ST_IDLE; cnt_q <= '0; end
                  else                        cnt_q <= cnt_q + 1'b1;
               end
               ST_IDLE: if (!din) begin state <= ST_ID; cnt_q <= '0; end
               ST_ID: begin
                  if (cnt_q == ID_LAST) begin state <= ST_RTR; cnt_q <= '0; end
                  else cnt_q <= cnt_q + 1'b1;
               end
               ST_RTR: state <= ST_IDE;
               ST_IDE: begin
                  if (din) begin
                     err_q <= 1'b1; code_q <= ERR_EXT; state <= ST_WAIT; cnt_q <= '0;
                  end else state <= ST_RSV;
               end
               ST_RSV: begin state <= ST_DLC; cnt_q <= '0; end
               ST_DLC: begin
                  if (cnt_q == DLC_LAST) begin
                     nbytes_q <= nb_next;
                     cnt_q    <= '0;
                     state    <= (nb_next == '0) ? ST_CRC : ST_DATA;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               ST_DATA: begin
                  if (cnt_q == data_last) begin state <= ST_CRC; cnt_q <= '0; end
                  else cnt_q <= cnt_q + 1'b1;
               end
               ST_CRC: begin
                  if (cnt_q == CRC_LAST) begin state <= ST_CDEL; cnt_q <= '0; end
                  else cnt_q <= cnt_q + 1'b1;
               end
               ST_CDEL: begin
                  if (!din) begin
                     err_q <= 1'b1; code_q <= ERR_FORM; state <= ST_WAIT;
                  end else if (!crc_zero) begin
                     err_q <= 1'b1; code_q <= ERR_CRC; state <= ST_WAIT;
                  end else begin
                     state <= ST_ACK; tx_q <= 1'b0;
                  end
               end
               ST_ACK: begin tx_q <= 1'b1; state <= ST_ADEL; end
               ST_ADEL: begin
                  if (!din) begin
                     err_q <= 1'b1; code_q <= ERR_FORM; state <= ST_WAIT;
                  end else begin
                     state <= ST_EOF; cnt_q <= '0;
                  end
               end
               ST_EOF: begin
                  if (!din) begin
                     err_q <= 1'b1; code_q <= ERR_FORM; state <= ST_WAIT; cnt_q <= '0;
                  end else if (cnt_q == EOF_LAST) begin
                     valid_q <= 1'b1; state <= ST_WAIT; cnt_q <= '0;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               default: begin state <= ST_WAIT; cnt_q <= '0; end
            endcase
         end
      end
   end

   assign cnt       = cnt_q;
   assign valid     = valid_q;
   assign err_valid = err_q;
   assign err_code  = code_q;
   assign tx_bit    = tx_q;

endmodule

// File: rtl/can_std_rx.sv
module can_std_rx
   import can_rx_pkg::*;
#(
   parameter int              ID_W      = 11,
   parameter int              DLC_W     = 4,
   parameter int              MAX_BYTES = 8,
   parameter int              CRC_W     = 15,
   parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599,
   parameter int              EOF_BITS  = 7,
   parameter int              IDLE_BITS = 11,
   localparam int             DATA_W    = MAX_BYTES * 8,
   localparam int             MAXC      = max_of(max_of(DATA_W, IDLE_BITS),
                                                 max_of(max_of(ID_W, CRC_W), EOF_BITS)),
   localparam int             CNT_W     = $clog2(MAXC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              rx_bit,
   output logic              tx_bit,
   output logic              frm_valid,
   output logic [ID_W-1:0]   frm_id,
   output logic              frm_rtr,
   output logic [DLC_W-1:0]  frm_dlc,
   output logic [DATA_W-1:0] frm_data,
   output logic              err_valid,
   output logic [1:0]        err_code
);

   if (CRC_W < 2 || CRC_W > 32) begin : g_bad_crc
      $error("can_std_rx: CRC_W out of range");
   end
   if (MAX_BYTES < 1 || MAX_BYTES >= (1 << DLC_W)) begin : g_bad_bytes
      $error("can_std_rx: MAX_BYTES must fit the length code");
   end
   if (ID_W < 2 || DLC_W < 2 || EOF_BITS < 1 || IDLE_BITS < 2) begin : g_bad_fields
      $error("can_std_rx: field widths too small");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("can_std_rx: counter too narrow");
   end

   logic             crc_clr, crc_en, crc_zero;
   logic             cap_clr, load;
   cap_sel_e         cap_sel;
   logic [CNT_W-1:0] cnt;
   logic [DLC_W-1:0] dlc_live;

   can_rx_ctrl #(
      .ID_W(ID_W), .DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES), .CRC_W(CRC_W),
      .EOF_BITS(EOF_BITS), .IDLE_BITS(IDLE_BITS), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .stb(bit_stb), .din(rx_bit),
      .crc_zero(crc_zero), .dlc_live(dlc_live),
      .crc_clr(crc_clr), .crc_en(crc_en), .cap_clr(cap_clr), .cap_sel(cap_sel),
      .cnt(cnt), .load(load), .valid(frm_valid),
      .err_valid(err_valid), .err_code(err_code), .tx_bit(tx_bit)
   );

   can_rx_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
      .din(rx_bit), .zero(crc_zero)
   );

   can_rx_fields #(
      .ID_W(ID_W), .DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
   ) u_fields (
      .clk(clk), .rst_n(rst_n), .stb(bit_stb), .din(rx_bit),
      .clr(cap_clr), .sel(cap_sel), .cnt(cnt), .load(load),
      .dlc_live(dlc_live), .id_o(frm_id), .rtr_o(frm_rtr),
      .dlc_o(frm_dlc), .data_o(frm_data)
   );

endmodule

// File: rtl/can_std_rx_chk.sv
module can_std_rx_chk #(
   parameter int ID_W   = 11,
   parameter int DLC_W  = 4,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_stb,
   input logic              rx_bit,
   input logic              tx_bit,
   input logic              frm_valid,
   input logic [ID_W-1:0]   frm_id,
   input logic [DLC_W-1:0]  frm_dlc,
   input logic [DATA_W-1:0] frm_data,
   input logic              err_valid,
   input logic [1:0]        err_code
);

   // R7: acknowledge lasts a single bit time
   a_r7_ack_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !tx_bit) |=> tx_bit);

   // R7: acknowledge starts only at a strobe that sampled a recessive bit
   a_r7_ack_after_delim: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_bit) |-> ($past(bit_stb) && $past(rx_bit)));

   a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(frm_valid && err_valid));

   a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> !frm_valid);

   a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |=> !err_valid);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(frm_id) || !$stable(frm_dlc) || !$stable(frm_data)) |-> frm_valid);

   // R2: outcome pulses follow a strobe
   a_r2_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid || err_valid) |-> $past(bit_stb));

   // R8: a good frame ends on a recessive bit
   a_r8_last_recessive: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> $past(rx_bit));

   // R3: an abort always carries a cause
   a_r3_code_set: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (err_code != 2'd0));

endmodule

bind can_std_rx can_std_rx_chk #(.ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit), .tx_bit(tx_bit),
   .frm_valid(frm_valid), .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data(frm_data),
   .err_valid(err_valid), .err_code(err_code)
);

// File: tb/can_std_rx_tb.sv
module can_std_rx_tb;

   localparam int CLK_PERIOD = 10;
   localparam int STB_GAP    = 4;
   localparam int IDLE_N     = 11;
   localparam logic [1:0] C_OK = 2'd0, C_FORM = 2'd1, C_EXT = 2'd2, C_CRC = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_stb = 1'b0;
   logic        rx_bit = 1'b1;
   logic        tx_bit, frm_valid, frm_rtr, err_valid;
   logic [10:0] frm_id;
   logic [3:0]  frm_dlc;
   logic [63:0] frm_data;
   logic [1:0]  err_code;

   int checks = 0, failures = 0;
   int n_valid = 0, n_err = 0;
   logic [10:0] cap_id;
   logic        cap_rtr;
   logic [3:0]  cap_dlc;
   logic [63:0] cap_data;
   logic [1:0]  cap_code;

   logic fb[$];
   int   cdel_idx, ack_idx;

   can_std_rx u_dut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit), .tx_bit(tx_bit),
      .frm_valid(frm_valid), .frm_id(frm_id), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
      .frm_data(frm_data), .err_valid(err_valid), .err_code(err_code)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) begin
         if (frm_valid) begin
            n_valid++;
            cap_id = frm_id; cap_rtr = frm_rtr; cap_dlc = frm_dlc; cap_data = frm_data;
         end
         if (err_valid) begin
            n_err++;
            cap_code = err_code;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [14:0] crc_ref(input int n);
      logic [14:0] c = '0;
      for (int i = 0; i < n; i++) begin
         logic f = fb[i] ^ c[14];
         c = {c[13:0], 1'b0};
         if (f) c = c ^ 15'h4599;
      end
      return c;
   endfunction

   function automatic int nbytes(input logic [3:0] dlc);
      return (dlc > 4'd8) ? 8 : int'(dlc);
   endfunction

   function automatic logic [63:0] mask_data(input logic [3:0] dlc, input logic [63:0] d);
      logic [63:0] m = d;
      for (int k = 0; k < 8; k++) if (k >= nbytes(dlc)) m[8*k +: 8] = 8'h00;
      return m;
   endfunction

   task automatic build(input logic [10:0] id, input logic rtr, ide, r0,
                        input logic [3:0] dlc, input logic [63:0] data);
      logic [14:0] c;
      fb.delete();
      fb.push_back(1'b0);
      for (int i = 10; i >= 0; i--) fb.push_back(id[i]);
      fb.push_back(rtr); fb.push_back(ide); fb.push_back(r0);
      for (int i = 3; i >= 0; i--) fb.push_back(dlc[i]);
      for (int k = 0; k < nbytes(dlc); k++)
         for (int b = 7; b >= 0; b--) fb.push_back(data[8*k + b]);
      c = crc_ref(fb.size());
      for (int i = 14; i >= 0; i--) fb.push_back(c[i]);
      cdel_idx = fb.size();
      ack_idx  = cdel_idx + 1;
      for (int i = 0; i < 10; i++) fb.push_back(1'b1);
   endtask

   task automatic send_bit(input logic b, output logic tx_seen);
      @(negedge clk);
      tx_seen = tx_bit;
      rx_bit  = b & tx_bit;   // wired-AND bus
      bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
      repeat (STB_GAP - 2) @(negedge clk);
   endtask

   task automatic send_idle(input int n);
      logic t;
      for (int i = 0; i < n; i++) send_bit(1'b1, t);
   endtask

   task automatic run_frame(input string tag, input logic [10:0] id, input logic rtr,
                            input logic ide, input logic r0, input logic [3:0] dlc,
                            input logic [63:0] data, input int flip_idx,
                            input int force_idx, input logic [1:0] exp_code);
      int stop, base_v, base_e, low_cnt, low_at, exp_low;
      logic t;
      build(id, rtr, ide, r0, dlc, data);
      if (flip_idx >= 0)  fb[flip_idx]  = ~fb[flip_idx];
      if (force_idx >= 0) fb[force_idx] = 1'b0;
      case (exp_code)
         C_EXT:   stop = 14;
         C_CRC:   stop = cdel_idx + 1;
         C_FORM:  stop = force_idx + 1;
         default: stop = fb.size();
      endcase
      base_v = n_valid; base_e = n_err; low_cnt = 0; low_at = -1;
      for (int i = 0; i < stop; i++) begin
         send_bit(fb[i], t);
         if (!t) begin low_cnt++; low_at = i; end
      end
      send_idle(IDLE_N);
      if (exp_code == C_OK) begin
         check(n_valid == base_v + 1, tag, "R2 valid count", 64'(n_valid - base_v), 64'd1);
         check(n_err == base_e, tag, "R9 no error", 64'(n_err - base_e), 64'd0);
         check(cap_id == id, tag, "R2 id", 64'(cap_id), 64'(id));
         check(cap_rtr == rtr, tag, "R2 rtr", 64'(cap_rtr), 64'(rtr));
         check(cap_dlc == dlc, tag, "R5 raw dlc", 64'(cap_dlc), 64'(dlc));
         check(cap_data == mask_data(dlc, data), tag, "R5 data", cap_data, mask_data(dlc, data));
         check(low_cnt == 1 && low_at == ack_idx, tag, "R7 ack slot",
               64'(low_at), 64'(ack_idx));
      end else begin
         exp_low = (exp_code == C_FORM && force_idx > ack_idx) ? 1 : 0;
         check(n_valid == base_v, tag, "no valid on abort", 64'(n_valid - base_v), 64'd0);
         check(n_err == base_e + 1, tag, "R9 one error pulse", 64'(n_err - base_e), 64'd1);
         check(cap_code == exp_code, tag, "error code", 64'(cap_code), 64'(exp_code));
         check(low_cnt == exp_low, tag, "R7 ack count", 64'(low_cnt), 64'(exp_low));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic t;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(tx_bit == 1'b1, "R7", "reset tx", 64'(tx_bit), 64'd1);
      check(frm_valid == 1'b0 && err_valid == 1'b0, "R9", "reset pulses",
            64'({frm_valid, err_valid}), 64'd0);
      check(frm_id == '0 && frm_data == '0, "R9", "reset outputs", frm_data, 64'd0);

      // R1: a dominant bit before the idle run completes is not a start
      send_idle(IDLE_N - 1);
      send_bit(1'b0, t);
      send_idle(IDLE_N);
      check(n_valid == 0 && n_err == 0, "R1", "early dominant ignored",
            64'(n_valid + n_err), 64'd0);
      run_frame("R1", 11'h123, 1'b0, 1'b0, 1'b0, 4'd2, 64'h0000_0000_0000_A55A, -1, -1, C_OK);

      // directed corner cases
      run_frame("R2", 11'h7FF, 1'b1, 1'b0, 1'b0, 4'd0, 64'h0, -1, -1, C_OK);
      run_frame("R2", 11'h000, 1'b0, 1'b0, 1'b0, 4'd1, 64'hFF, -1, -1, C_OK);
      run_frame("R4", 11'h2A5, 1'b0, 1'b0, 1'b1, 4'd8, 64'h0123_4567_89AB_CDEF, -1, -1, C_OK);
      run_frame("R5", 11'h155, 1'b0, 1'b0, 1'b0, 4'd15, 64'hDEAD_BEEF_CAFE_F00D, -1, -1, C_OK);
      run_frame("R5", 11'h0F0, 1'b1, 1'b0, 1'b1, 4'd9, 64'h1111_2222_3333_4444, -1, -1, C_OK);
      run_frame("R3", 11'h321, 1'b0, 1'b1, 1'b0, 4'd3, 64'h00AB_CDEF, -1, -1, C_EXT);
      run_frame("R6", 11'h444, 1'b0, 1'b0, 1'b0, 4'd4, 64'h1234_5678, 25, -1, C_CRC);
      run_frame("R8", 11'h011, 1'b0, 1'b0, 1'b0, 4'd1, 64'h3C, -1, 19 + 8 + 15, C_FORM);
      run_frame("R8", 11'h022, 1'b0, 1'b0, 1'b0, 4'd0, 64'h0, -1, 19 + 15 + 2, C_FORM);
      run_frame("R8", 11'h033, 1'b1, 1'b0, 1'b0, 4'd2, 64'h9999, -1, 19 + 16 + 15 + 9, C_FORM);

      // random frames, some with a flipped data or checksum bit
      for (int n = 0; n < 40; n++) begin
         logic [10:0] id  = 11'($urandom);
         logic        rtr = 1'($urandom);
         logic        r0  = 1'($urandom);
         logic [3:0]  dlc = 4'($urandom);
         logic [63:0] d   = {$urandom, $urandom};
         int span = nbytes(dlc) * 8 + 15;
         if (($urandom % 4) == 0)
            run_frame("R6", id, rtr, 1'b0, r0, dlc, d, 19 + int'($urandom % span), -1, C_CRC);
         else
            run_frame("R5", id, rtr, 1'b0, r0, dlc, d, -1, -1, C_OK);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule